// File: doc/BRIEF.md
# Byte/Word ALU with Status Register

This block combines a 16-bit arithmetic and logic unit with the processor status word whose condition flags it maintains. Each operation works on either the full 16-bit operands or only their low bytes. The byte/word select decides which bits the result and all four condition flags (carry, zero, negative, overflow) are taken from. Six operations are available: add, subtract, compare, AND, OR and XOR. Compare subtracts and updates the flags, but leaves the result register untouched.

The same status word also holds the global interrupt enable, the two oscillator/CPU off bits and the two clock-generator bits. Hardware events change some of these. An interrupt-entry pulse clears the interrupt enable and the CPU-off bit, and also clears the oscillator-off bit when the interrupt is external. A return pulse sets the interrupt enable again. Software can overwrite every defined bit directly. The power-mode bits are only stored and read back.

Operations are presented as a one-cycle strobe with plain control pins; there is no back-pressure. The result and the status word are both registered and show the effect of a strobe one clock after the edge that samples it.

Top module: `bw_alu_status`

## Requirements
- R1: After reset, `result` and `status` are both 16'h0000.
- R2: With op_code 0 (add) in word mode, `result` becomes src_a+src_b modulo 2^16 one cycle after the strobe, and the carry flag (status bit 0) is the carry out of bit 15.
- R3: With op_code 1 (subtract), `result` becomes src_a-src_b. Carry is 1 when no borrow occurred (src_a >= src_b unsigned in the selected width).
- R4: With op_code 2 (compare), the flags update exactly as for subtract and `result` keeps its previous value.
- R5: In byte mode only bits 7:0 of the operands take part. Result bits 15:8 are zero, carry comes out of bit 7, negative copies result bit 7, and zero tests only bits 7:0.
- R6: Negative (bit 2) equals the result MSB and zero (bit 1) is set for an all-zero result. For add and subtract, overflow (bit 8) is set when two same-sign inputs to the adder give a result of the other sign.
- R7: op_codes 3, 4 and 5 (AND, OR, XOR) clear overflow, set carry to the inverse of zero, and set negative and zero from the result.
- R8: With `flag_we` low, an operation still updates `result` but leaves all status bits unchanged.
- R9: op_codes 6 and 7 change neither `result` nor `status`.
- R10: The status layout is carry 0, zero 1, negative 2, interrupt enable 3, CPU off 4, oscillator off 5, clock-gen 0 at 6, clock-gen 1 at 7, overflow 8. Bits 15:9 always read zero and ignore writes.
- R11: `irq_enter` clears bit 3 and bit 4. When `irq_ext` is also high, it clears bit 5 as well.
- R12: `irq_return` sets bit 3. When `irq_enter` is high in the same cycle, the clear wins.
- R13: `sr_wr_en` loads `sr_wr_data` into bits 8:0 one cycle later. It takes priority over flag updates and interrupt events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one per cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6/7 none |
| byte_mode | input | 1 | 1 selects low-byte operation |
| flag_we | input | 1 | Allow the operation to update condition flags |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand (subtrahend) |
| sr_wr_en | input | 1 | Software write of the status word |
| sr_wr_data | input | 16 | Value for the software write |
| irq_enter | input | 1 | Interrupt taken pulse |
| irq_ext | input | 1 | Qualifies irq_enter as an external interrupt |
| irq_return | input | 1 | Return-from-interrupt pulse |
| result | output | 16 | Registered ALU result |
| status | output | 16 | Registered status word |

## Verification
The arithmetic is tried with operands at the signed and unsigned boundaries: 16'h7FFF+1, 16'hFFFF+1, 8'h80+8'h80, and equal-valued compares. These separate the carry, overflow and zero paths, and show whether byte mode takes its flags from bit 7 or from bit 15. Byte cases carry non-zero upper operand bytes, so that leakage into the result or the zero flag shows up. Logical operations run on patterns that give both zero and non-zero results, to expose the carry-equals-not-zero rule. Directed cycles with simultaneous software writes, interrupt entry and return confirm the priorities. A long random stream then runs every op code, both widths and the event inputs against a behavioural model.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5
  } alu_op_e;

  localparam int unsigned SB_C    = 0;
  localparam int unsigned SB_Z    = 1;
  localparam int unsigned SB_N    = 2;
  localparam int unsigned SB_IE   = 3;
  localparam int unsigned SB_CPU  = 4;
  localparam int unsigned SB_OSC  = 5;
  localparam int unsigned SB_V    = 8;
  localparam int unsigned SR_USED = 9;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } cond_t;
endpackage

// File: rtl/bw_alu_core.sv
module bw_alu_core
  import bw_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [2:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output cond_t        cond,
  output logic         known_op,
  output logic         writes_res
);
  localparam int unsigned HALF = W / 2;

  logic         is_sub, is_arith;
  logic [W-1:0] b_eff, logic_res, arith_res, mask;
  logic [W:0]   wsum;
  logic [HALF:0] bsum;
  logic         carry, msb_a, msb_b, msb_r, zero;

  always_comb begin
    is_sub     = (op == OP_SUB) || (op == OP_CMP);
    is_arith   = is_sub || (op == OP_ADD);
    known_op   = (op <= OP_XOR);
    writes_res = known_op && (op != OP_CMP);
    mask       = {{HALF{~byte_mode}}, {HALF{1'b1}}};
    b_eff      = is_sub ? ~b : b;

    wsum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    bsum = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, is_sub};

    arith_res = byte_mode ? {{HALF{1'b0}}, bsum[HALF-1:0]} : wsum[W-1:0];
    carry     = byte_mode ? bsum[HALF] : wsum[W];

    case (op)
      OP_AND:  logic_res = a & b;
      OP_OR:   logic_res = a | b;
      default: logic_res = a ^ b;
    endcase

    res   = (is_arith ? arith_res : logic_res) & mask;
    msb_a = byte_mode ? a[HALF-1]     : a[W-1];
    msb_b = byte_mode ? b_eff[HALF-1] : b_eff[W-1];
    msb_r = byte_mode ? res[HALF-1]   : res[W-1];
    zero  = byte_mode ? (res[HALF-1:0] == '0) : (res == '0);

    cond.z = zero;
    cond.n = msb_r;
    cond.c = is_arith ? carry : ~zero;
    cond.v = is_arith && (msb_a == msb_b) && (msb_r != msb_a);
  end
endmodule

// File: rtl/bw_status_reg.sv
module bw_status_reg
  import bw_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_upd,
  input  cond_t        cond,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         irq_enter,
  input  logic         irq_ext,
  input  logic         irq_return,
  output logic [W-1:0] sr
);
  localparam logic [W-1:0] USED_MASK = W'((1 << SR_USED) - 1);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (sw_we) begin
      sr_d = sw_data & USED_MASK;
    end else begin
      if (flag_upd) begin
        sr_d[SB_C] = cond.c;
        sr_d[SB_Z] = cond.z;
        sr_d[SB_N] = cond.n;
        sr_d[SB_V] = cond.v;
      end
      if (irq_enter) begin
        sr_d[SB_IE]  = 1'b0;
        sr_d[SB_CPU] = 1'b0;
        if (irq_ext) sr_d[SB_OSC] = 1'b0;
      end else if (irq_return) begin
        sr_d[SB_IE] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d & USED_MASK;
  end

  assign sr = sr_q;
endmodule

// File: rtl/bw_alu_status.sv
module bw_alu_status
  import bw_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic         byte_mode,
  input  logic         flag_we,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         sr_wr_en,
  input  logic [W-1:0] sr_wr_data,
  input  logic         irq_enter,
  input  logic         irq_ext,
  input  logic         irq_return,
  output logic [W-1:0] result,
  output logic [W-1:0] status
);
  logic [W-1:0] core_res, res_q;
  cond_t        core_cond;
  logic         known_op, writes_res;

  bw_alu_core #(.W(W)) u_core (
    .op         (op_code),
    .byte_mode  (byte_mode),
    .a          (src_a),
    .b          (src_b),
    .res        (core_res),
    .cond       (core_cond),
    .known_op   (known_op),
    .writes_res (writes_res)
  );

  bw_status_reg #(.W(W)) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_upd   (op_valid && flag_we && known_op),
    .cond       (core_cond),
    .sw_we      (sr_wr_en),
    .sw_data    (sr_wr_data),
    .irq_enter  (irq_enter),
    .irq_ext    (irq_ext),
    .irq_return (irq_return),
    .sr         (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       res_q <= '0;
    else if (op_valid && writes_res)  res_q <= core_res;
  end

  assign result = res_q;
endmodule

// File: rtl/bw_alu_status_chk.sv
module bw_alu_status_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic         byte_mode,
  input logic         flag_we,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         sr_wr_en,
  input logic [W-1:0] sr_wr_data,
  input logic         irq_enter,
  input logic         irq_ext,
  input logic         irq_return,
  input logic [W-1:0] result,
  input logic [W-1:0] status
);
  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[W-1:9] == '0);

  // R11
  irq_enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !sr_wr_en) |=> (!status[3] && !status[4]));

  // R12
  irq_return_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && !sr_wr_en) |=> status[3]);

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && byte_mode && op_code <= 3'd5 && op_code != 3'd2) |=> (result[W-1:8] == '0));

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_we && !sr_wr_en && op_code >= 3'd3 && op_code <= 3'd5)
      |=> (!status[8] && (status[0] != status[1])));

  // R4
  cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> $stable(result));

  // R13
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> (status[8:0] == $past(sr_wr_data[8:0])));
endmodule

bind bw_alu_status bw_alu_status_chk #(.W(W)) u_chk (.*);

// File: tb/test_bw_alu_status.sv
module test_bw_alu_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, byte_mode = 0, flag_we = 0;
  logic [2:0]  op_code = 0;
  logic [15:0] src_a = 0, src_b = 0, sr_wr_data = 0;
  logic        sr_wr_en = 0, irq_enter = 0, irq_ext = 0, irq_return = 0;
  logic [15:0] result, status;

  int total = 0, bad = 0;
  string tag = "R1";
  int exp_res = 0, exp_sr = 0;

  always #10 clk = ~clk;

  bw_alu_status i_bw_alu_status (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .flag_we(flag_we), .src_a(src_a), .src_b(src_b),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .irq_enter(irq_enter),
    .irq_ext(irq_ext), .irq_return(irq_return), .result(result), .status(status)
  );

  // behavioural reference, updated at the sampling edge
  always @(posedge clk) begin
    if (rst_n) begin
      int m, a, b, r, sum, c, z, n, v, top, nr, ns;
      nr = exp_res;
      ns = exp_sr;
      m   = byte_mode ? 255 : 65535;
      top = byte_mode ? 128 : 32768;
      a = src_a & m;
      b = src_b & m;
      if (op_valid && op_code <= 5) begin
        if (op_code <= 2) begin
          if (op_code == 0) sum = a + b;
          else              sum = a + ((~b) & m) + 1;
          r = sum & m;
          c = (sum > m) ? 1 : 0;
          if (op_code == 0) v = ((a & top) == (b & top)) && ((r & top) != (a & top));
          else              v = ((a & top) != (b & top)) && ((r & top) != (a & top));
        end else begin
          if (op_code == 3)      r = a & b;
          else if (op_code == 4) r = a | b;
          else                   r = a ^ b;
          v = 0;
          c = (r != 0) ? 1 : 0;
        end
        z = (r == 0) ? 1 : 0;
        n = (r & top) ? 1 : 0;
        if (op_code != 2) nr = r;
        if (flag_we && !sr_wr_en)
          ns = (ns & ~32'h107) | c | (z << 1) | (n << 2) | (v << 8);
      end
      if (sr_wr_en) ns = sr_wr_data & 32'h1FF;
      else if (irq_enter) begin
        ns = ns & ~32'h18;
        if (irq_ext) ns = ns & ~32'h20;
      end else if (irq_return) ns = ns | 8;
      exp_res <= nr;
      exp_sr  <= ns;
    end
  end

  always @(negedge clk) begin
    total++;
    if (result !== 16'(exp_res)) begin
      bad++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, 16'(exp_res));
    end
    total++;
    if (status !== 16'(exp_sr)) begin
      bad++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, 16'(exp_sr));
    end
  end

  task automatic idle();
    op_valid = 0; sr_wr_en = 0; irq_enter = 0; irq_ext = 0; irq_return = 0;
  endtask

  task automatic do_op(input string t, input logic [2:0] op, input logic bm,
                       input logic fw, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    idle();
    tag = t; op_valid = 1; op_code = op; byte_mode = bm; flag_we = fw;
    src_a = a; src_b = b;
  endtask

  task automatic direct_check(input string t, input logic [15:0] act, input logic [15:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp_v);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    direct_check("R1", result, 16'h0000);
    direct_check("R1", status, 16'h0000);
    rst_n = 1;
    do_op("R2", 3'd0, 0, 1, 16'h7FFF, 16'h0001);   // V,N set
    do_op("R2", 3'd0, 0, 1, 16'hFFFF, 16'h0001);   // C,Z set
    do_op("R6", 3'd0, 0, 1, 16'h1234, 16'h1111);
    do_op("R3", 3'd1, 0, 1, 16'h0005, 16'h0007);   // borrow
    do_op("R3", 3'd1, 0, 1, 16'h8000, 16'h0001);   // overflow
    do_op("R4", 3'd2, 0, 1, 16'h4444, 16'h4444);   // Z,C, result kept
    do_op("R5", 3'd0, 1, 1, 16'h1280, 16'h3480);   // byte C,Z,V
    do_op("R5", 3'd1, 1, 1, 16'hFF10, 16'h0020);   // byte negative
    @(negedge clk); idle();
    @(negedge clk);
    direct_check("R5", result, 16'h00F0);
    direct_check("R5", status & 16'h0107, 16'h0004);
    do_op("R7", 3'd3, 0, 1, 16'hF0F0, 16'h0F0F);
    do_op("R7", 3'd4, 0, 1, 16'h8000, 16'h0001);
    do_op("R7", 3'd5, 1, 1, 16'hAB55, 16'hCD55);
    do_op("R8", 3'd0, 0, 0, 16'hFFFF, 16'h0001);
    do_op("R9", 3'd6, 0, 1, 16'h0001, 16'h0002);
    do_op("R9", 3'd7, 1, 1, 16'h0003, 16'h0004);
    @(negedge clk); idle(); tag = "R10"; sr_wr_en = 1; sr_wr_data = 16'hFFFF;
    @(negedge clk); idle();
    direct_check("R10", status, 16'h01FF);
    tag = "R11"; irq_enter = 1;
    @(negedge clk); idle();
    direct_check("R11", status, 16'h01E7);
    tag = "R12"; irq_return = 1;
    @(negedge clk); idle();
    direct_check("R12", status, 16'h01EF);
    tag = "R11"; irq_enter = 1; irq_ext = 1; irq_return = 1;
    @(negedge clk); idle();
    direct_check("R12", status, 16'h01C7);
    tag = "R13"; sr_wr_en = 1; sr_wr_data = 16'h0A18; irq_return = 1;
    op_valid = 1; op_code = 3'd0; flag_we = 1; src_a = 16'hFFFF; src_b = 16'h0001;
    @(negedge clk); idle();
    direct_check("R13", status, 16'h0018);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      tag = "R6";
      op_valid = 1'($urandom_range(0, 3) != 0);
      op_code = 3'($urandom_range(0, 7));
      byte_mode = 1'($urandom);
      flag_we = 1'($urandom_range(0, 3) != 0);
      src_a = 16'($urandom); src_b = 16'($urandom);
      if ($urandom_range(0, 7) == 0) src_b = src_a;
      sr_wr_en = 1'($urandom_range(0, 15) == 0);
      sr_wr_data = 16'($urandom);
      irq_enter = 1'($urandom_range(0, 7) == 0);
      irq_ext = 1'($urandom);
      irq_return = 1'($urandom_range(0, 7) == 0);
    end
    @(negedge clk); idle();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule